// File: doc/BRIEF.md
# PCIe Switch Port Bridge Configuration Register File

This block holds the Type 1 (bridge) configuration header of one PCIe switch port, followed by a power management capability header and a PCI Express capability with its device and link control fields. Configuration requests arrive as a dword address, a write flag, byte enables and write data. One cycle after the request, the block answers with read data and a three-bit completion status. Each register field has its own reset value and its own write mask. Bits outside the mask keep their value, and the status fields are write-one-to-clear.

A static strap input, `upstream`, chooses between upstream-port and downstream-port behaviour. The strap changes the BAR write masks, the PCI Express capability value and the link control mask. Type 1 requests are not decoded locally; they are passed out on a forwarding port one cycle later. Writes that touch an I/O, memory or prefetchable window register produce a one-cycle update pulse that names the window. Two set inputs let error logic raise bits in the primary and secondary status registers.

Top module: `bridgeCfgSpace`

## Requirements
- R1: A Type 0 request with dword address 0x400 or above (byte offset 0x1000 or more) completes with status 3'b001 (Unsupported Request), returns read data 0, changes no register and raises no window pulse.
- R2: A Type 0 request completes one cycle after it is presented (`cplValid` high for one cycle). Status is 3'b000 (Successful Completion) when accepted, and 3'b100 (Completer Abort) when all byte enables are zero. An aborted write changes nothing. Write completions return data 0.
- R3: Byte enable bit n gates write data bits 8n+7..8n. A read returns the whole dword. Offsets below 0x1000 with no register read 0 and ignore writes. Reads are side-effect free.
- R4: Byte offset 0x04: the command field [15:0] resets to 0 with write mask 0x0547. The status field [31:16] resets to 0x0010. Its bits under mask 0xC900 are write-one-to-clear and are set by `priStatusSet`. A set and a clear in the same cycle leave the bit set.
- R5: Identity registers are read-only. Offset 0x00 reads 0x0B171E5A. Offset 0x08 reads 0x06040002 (base class 0x06, subclass 0x04, interface 0x00, revision 0x02). Offset 0x0C has header type 0x01 in [23:16] and a writable cache line field [7:0].
- R6: BAR0 (0x10) has write mask 0xFFFE0000 and BAR1 (0x14) has mask 0xFFFFFFFF on an upstream port. On a downstream port both read 0 and ignore writes.
- R7: Offset 0x18 holds primary [7:0], secondary [15:8] and subordinate [23:16] bus numbers. All three are fully writable and reset to 0. Bits [31:24] read 0.
- R8: Window registers, as reset value/mask:
  - 0x1C: I/O base [7:0] 0xF1/0xF0, I/O limit [15:8] 0x01/0xF0, secondary status [31:16] 0 with write-one-to-clear mask 0xC100 set by `secStatusSet`.
  - 0x20: memory base 0xFFF0 and limit 0x0000, both with mask 0xFFF0.
  - 0x24: prefetchable base 0xFFF1 and limit 0x0001, both with mask 0xFFF0.
  - 0x28 and 0x2C: upper parts, 0 with mask 0xFFFFFFFF.
  - 0x30: I/O upper base 0xFFFF and limit 0x0000, both fully writable.
- R9: Offset 0x34 reads 0x40. Offset 0x3C: interrupt line [7:0] is writable, interrupt pin [15:8] reads 0x01, bridge control [31:16] has mask 0x005F and resets to 0. Offset 0x40 reads 0xC8024801.
- R10: Offset 0x48 reads capability ID 0x10 in [7:0], with [31:16] equal to 0x0051 upstream or 0x0161 downstream. Offset 0x50 device control [15:0] has mask 0x00EF; device status bits 0xF in [19:16] are write-one-to-clear. Offset 0x58 link control [15:0] has mask 0x00C3 upstream or 0x00F3 downstream, and link status [31:16] reads 0x0011.
- R11: A Type 1 request raises `fwdValid` for one cycle, one cycle later, carrying its write flag, address, byte enables and data. It produces no local completion and changes no register.
- R12: An accepted write raises `winUpdValid` for one cycle, one cycle later, with a one-hot `winUpdSel` naming the window: bit 0 I/O, bit 1 memory, bit 2 prefetchable.
  - I/O: offset 0x1C with byte lane 0 or 1 enabled, or offset 0x30.
  - Memory: offset 0x20.
  - Prefetchable: offsets 0x24, 0x28 and 0x2C.
  - No other write raises the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| upstream | input | 1 | Static strap, 1 = upstream port |
| reqValid | input | 1 | Request present this cycle |
| reqType1 | input | 1 | Request is Type 1 (forward) |
| reqWrite | input | 1 | Request is a write |
| reqDwAddr | input | 14 | Dword address (byte offset / 4) |
| reqBe | input | 4 | Byte enables |
| reqWdata | input | 32 | Write data |
| priStatusSet | input | 16 | Set pulses for primary status bits |
| secStatusSet | input | 16 | Set pulses for secondary status bits |
| cplValid | output | 1 | Completion valid |
| cplStatus | output | 3 | Completion status code |
| cplRdata | output | 32 | Completion read data |
| fwdValid | output | 1 | Forwarded Type 1 request valid |
| fwdWrite | output | 1 | Forwarded write flag |
| fwdDwAddr | output | 14 | Forwarded dword address |
| fwdBe | output | 4 | Forwarded byte enables |
| fwdWdata | output | 32 | Forwarded write data |
| winUpdValid | output | 1 | Window update pulse |
| winUpdSel | output | 3 | One-hot window selector |

## Verification
The hardest case to reach is a write-one-to-clear bit that an error event sets in the same cycle as a write that clears it. The outcome is only visible on a later read, and a bench that never drives the set inputs could never see a status bit at one at all. The stimulus therefore raises the set inputs both in idle cycles and on the exact cycle of a clearing write, and then reads the register back. The bench runs both strap values through reset and mixes random offsets, byte enables and request types. That mix exposes the strap-dependent masks, the lane gating, and the byte-lane condition that separates an I/O window pulse from a secondary status write on the same dword.

// File: rtl/bridgeCfgPkg.sv
package bridgeCfgPkg;
  localparam int DATA_BITS      = 32;
  localparam int BE_BITS        = DATA_BITS / 8;
  localparam int SPACE_BYTES    = 4096;
  localparam int IDX_BITS       = $clog2(SPACE_BYTES / BE_BITS);
  localparam int ADDR_BITS      = IDX_BITS + 4;
  localparam int NUM_DW         = 24;
  localparam int SEL_BITS       = $clog2(NUM_DW);
  localparam int WIN_COUNT      = 3;

  localparam logic [15:0] VENDOR_CODE = 16'h1e5a;
  localparam logic [15:0] DEVICE_CODE = 16'h0b17;
  localparam logic [7:0]  REV_CODE    = 8'h02;

  localparam logic [2:0] CPL_SC = 3'b000;
  localparam logic [2:0] CPL_UR = 3'b001;
  localparam logic [2:0] CPL_CA = 3'b100;

  typedef struct packed {
    logic                 wrEn;
    logic                 rdEn;
    logic [IDX_BITS-1:0]  dwIdx;
    logic [BE_BITS-1:0]   be;
    logic [DATA_BITS-1:0] wdata;
  } cfgStrobe_t;

  function automatic logic [31:0] cfgReset(input int idx, input logic up);
    case (idx)
      0:  return {DEVICE_CODE, VENDOR_CODE};
      1:  return 32'h0010_0000;
      2:  return {8'h06, 8'h04, 8'h00, REV_CODE};
      3:  return 32'h0001_0000;
      7:  return 32'h0000_01f1;
      8:  return 32'h0000_fff0;
      9:  return 32'h0001_fff1;
      12: return 32'h0000_ffff;
      13: return 32'h0000_0040;
      15: return 32'h0000_0100;
      16: return 32'hc802_4801;
      18: return up ? 32'h0051_0010 : 32'h0161_0010;
      22: return 32'h0011_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] cfgWrMask(input int idx, input logic up);
    case (idx)
      1:  return 32'h0000_0547;
      3:  return 32'h0000_00ff;
      4:  return up ? 32'hfffe_0000 : 32'h0;
      5:  return up ? 32'hffff_ffff : 32'h0;
      6:  return 32'h00ff_ffff;
      7:  return 32'h0000_f0f0;
      8, 9: return 32'hfff0_fff0;
      10, 11, 12: return 32'hffff_ffff;
      15: return 32'h005f_00ff;
      20: return 32'h0000_00ef;
      22: return up ? 32'h0000_00c3 : 32'h0000_00f3;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] cfgW1cMask(input int idx);
    case (idx)
      1:  return 32'hc900_0000;
      7:  return 32'hc100_0000;
      20: return 32'h000f_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] cfgSetVec(input int idx, input logic [15:0] pri,
                                            input logic [15:0] sec);
    case (idx)
      1:  return {pri, 16'h0};
      7:  return {sec, 16'h0};
      default: return 32'h0;
    endcase
  endfunction
endpackage

// File: rtl/bridgeCfgCtrl.sv
module bridgeCfgCtrl
  import bridgeCfgPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqType1,
  input  logic                 reqWrite,
  input  logic [ADDR_BITS-1:0] reqDwAddr,
  input  logic [BE_BITS-1:0]   reqBe,
  input  logic [DATA_BITS-1:0] reqWdata,
  output cfgStrobe_t           stb,
  output logic                 cplValid,
  output logic [2:0]           cplStatus,
  output logic                 fwdValid,
  output logic                 fwdWrite,
  output logic [ADDR_BITS-1:0] fwdDwAddr,
  output logic [BE_BITS-1:0]   fwdBe,
  output logic [DATA_BITS-1:0] fwdWdata,
  output logic                 winUpdValid,
  output logic [WIN_COUNT-1:0] winUpdSel
);
  localparam logic [ADDR_BITS-1:0] SPACE_DW = ADDR_BITS'(SPACE_BYTES / BE_BITS);

  logic isLocal, outOfSpace, noLanes, accept;
  logic [IDX_BITS-1:0] idx;
  logic [WIN_COUNT-1:0] winHit;

  assign isLocal    = reqValid && !reqType1;
  assign outOfSpace = reqDwAddr >= SPACE_DW;
  assign noLanes    = (reqBe == '0);
  assign accept     = isLocal && !outOfSpace && !noLanes;
  assign idx        = reqDwAddr[IDX_BITS-1:0];

  always_comb begin
    stb.wrEn  = accept && reqWrite;
    stb.rdEn  = accept && !reqWrite;
    stb.dwIdx = idx;
    stb.be    = reqBe;
    stb.wdata = reqWdata;
  end

  always_comb begin
    winHit = '0;
    if (stb.wrEn) begin
      winHit[0] = (idx == IDX_BITS'(7) && (reqBe[0] || reqBe[1])) || idx == IDX_BITS'(12);
      winHit[1] = (idx == IDX_BITS'(8));
      winHit[2] = (idx >= IDX_BITS'(9)) && (idx <= IDX_BITS'(11));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cplValid    <= 1'b0;
      cplStatus   <= CPL_SC;
      fwdValid    <= 1'b0;
      fwdWrite    <= 1'b0;
      fwdDwAddr   <= '0;
      fwdBe       <= '0;
      fwdWdata    <= '0;
      winUpdValid <= 1'b0;
      winUpdSel   <= '0;
    end else begin
      cplValid    <= isLocal;
      cplStatus   <= outOfSpace ? CPL_UR : (noLanes ? CPL_CA : CPL_SC);
      fwdValid    <= reqValid && reqType1;
      if (reqValid && reqType1) begin
        fwdWrite  <= reqWrite;
        fwdDwAddr <= reqDwAddr;
        fwdBe     <= reqBe;
        fwdWdata  <= reqWdata;
      end
      winUpdValid <= |winHit;
      winUpdSel   <= winHit;
    end
  end
endmodule

// File: rtl/bridgeCfgData.sv
module bridgeCfgData
  import bridgeCfgPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 upstream,
  input  cfgStrobe_t           stb,
  input  logic [15:0]          priSet,
  input  logic [15:0]          secSet,
  output logic [DATA_BITS-1:0] rdData
);
  logic [DATA_BITS-1:0] laneMask;
  logic [NUM_DW-1:0][DATA_BITS-1:0] dwArr;

  always_comb begin
    for (int b = 0; b < BE_BITS; b++) laneMask[8*b +: 8] = {8{stb.be[b]}};
  end

  generate
    for (genvar gi = 0; gi < NUM_DW; gi++) begin : g_dw
      logic [DATA_BITS-1:0] dwQ, dwD, wm, cm;
      logic hit;
      assign wm  = cfgWrMask(gi, upstream);
      assign cm  = cfgW1cMask(gi);
      assign hit = stb.wrEn && (stb.dwIdx == IDX_BITS'(gi));
      always_comb begin
        dwD = dwQ;
        if (hit) begin
          dwD = (dwQ & ~(wm & laneMask)) | (stb.wdata & wm & laneMask);
          dwD = dwD & ~(stb.wdata & cm & laneMask);
        end
        dwD = dwD | (cfgSetVec(gi, priSet, secSet) & cm);
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) dwQ <= cfgReset(gi, upstream);
        else       dwQ <= dwD;
      end
      assign dwArr[gi] = dwQ;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (stb.rdEn && stb.dwIdx < IDX_BITS'(NUM_DW)) rdData <= dwArr[stb.dwIdx[SEL_BITS-1:0]];
    else rdData <= '0;
  end
endmodule

// File: rtl/bridgeCfgSpace.sv
module bridgeCfgSpace
  import bridgeCfgPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        upstream,
  input  logic        reqValid,
  input  logic        reqType1,
  input  logic        reqWrite,
  input  logic [13:0] reqDwAddr,
  input  logic [3:0]  reqBe,
  input  logic [31:0] reqWdata,
  input  logic [15:0] priStatusSet,
  input  logic [15:0] secStatusSet,
  output logic        cplValid,
  output logic [2:0]  cplStatus,
  output logic [31:0] cplRdata,
  output logic        fwdValid,
  output logic        fwdWrite,
  output logic [13:0] fwdDwAddr,
  output logic [3:0]  fwdBe,
  output logic [31:0] fwdWdata,
  output logic        winUpdValid,
  output logic [2:0]  winUpdSel
);
  cfgStrobe_t stb;

  bridgeCfgCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqType1(reqType1),
    .reqWrite(reqWrite), .reqDwAddr(reqDwAddr), .reqBe(reqBe), .reqWdata(reqWdata),
    .stb(stb), .cplValid(cplValid), .cplStatus(cplStatus), .fwdValid(fwdValid),
    .fwdWrite(fwdWrite), .fwdDwAddr(fwdDwAddr), .fwdBe(fwdBe), .fwdWdata(fwdWdata),
    .winUpdValid(winUpdValid), .winUpdSel(winUpdSel)
  );

  bridgeCfgData i_data (
    .clk(clk), .rstN(rstN), .upstream(upstream), .stb(stb),
    .priSet(priStatusSet), .secSet(secStatusSet), .rdData(cplRdata)
  );
endmodule

// File: rtl/bridgeCfgSpaceChk.sv
module bridgeCfgSpaceChk (
  input logic        clk,
  input logic        rstN,
  input logic        upstream,
  input logic        reqValid,
  input logic        reqType1,
  input logic        reqWrite,
  input logic [13:0] reqDwAddr,
  input logic [3:0]  reqBe,
  input logic [31:0] reqWdata,
  input logic [15:0] priStatusSet,
  input logic [15:0] secStatusSet,
  input logic        cplValid,
  input logic [2:0]  cplStatus,
  input logic [31:0] cplRdata,
  input logic        fwdValid,
  input logic        fwdWrite,
  input logic [13:0] fwdDwAddr,
  input logic [3:0]  fwdBe,
  input logic [31:0] fwdWdata,
  input logic        winUpdValid,
  input logic [2:0]  winUpdSel
);
  a_r1_unsupported: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqType1 && reqDwAddr >= 14'h400) |=> (cplValid && cplStatus == 3'b001 && !winUpdValid));

  a_r2_one_cycle_cpl: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqType1) |=> cplValid);

  a_r2_abort: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqType1 && reqDwAddr < 14'h400 && reqBe == 4'h0) |=> (cplStatus == 3'b100 && cplRdata == 32'h0));

  a_r5_class_ro: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqType1 && !reqWrite && reqDwAddr == 14'h2 && reqBe != 4'h0) |=> (cplRdata == 32'h0604_0002));

  a_r6_down_bar_zero: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqType1 && !reqWrite && !upstream && (reqDwAddr == 14'h4 || reqDwAddr == 14'h5))
      |=> (cplRdata == 32'h0));

  a_r11_forward: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqType1) |=> (fwdValid && !cplValid && fwdDwAddr == $past(reqDwAddr) && fwdBe == $past(reqBe)));

  a_r11_no_spurious_fwd: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqType1) |=> !fwdValid);

  a_r12_onehot: assert property (@(posedge clk) disable iff (!rstN)
    winUpdValid |-> $countones(winUpdSel) == 1);

  a_r12_only_on_write: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqWrite && !reqType1) |=> !winUpdValid);
endmodule

bind bridgeCfgSpace bridgeCfgSpaceChk i_chk (.*);

// File: tb/test_bridgeCfgSpace.sv
`timescale 1ns/1ps
module test_bridgeCfgSpace;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        upstream = 1'b1;
  logic        reqValid = 1'b0, reqType1 = 1'b0, reqWrite = 1'b0;
  logic [13:0] reqDwAddr = '0;
  logic [3:0]  reqBe = '0;
  logic [31:0] reqWdata = '0;
  logic [15:0] priStatusSet = '0, secStatusSet = '0;
  logic        cplValid, fwdValid, fwdWrite, winUpdValid;
  logic [2:0]  cplStatus, winUpdSel;
  logic [31:0] cplRdata, fwdWdata;
  logic [13:0] fwdDwAddr;
  logic [3:0]  fwdBe;

  int nChecks = 0, nFail = 0;
  bit done = 0;
  logic [31:0] model [24];
  logic [15:0] pendPri = '0, pendSec = '0;

  always #4 clk = ~clk;

  bridgeCfgSpace i_bridgeCfgSpace (.*);

  function automatic logic [31:0] bRst(int i, bit up);
    case (i)
      0: return 32'h0b17_1e5a;  1: return 32'h0010_0000;  2: return 32'h0604_0002;
      3: return 32'h0001_0000;  7: return 32'h0000_01f1;  8: return 32'h0000_fff0;
      9: return 32'h0001_fff1;  12: return 32'h0000_ffff; 13: return 32'h0000_0040;
      15: return 32'h0000_0100; 16: return 32'hc802_4801;
      18: return up ? 32'h0051_0010 : 32'h0161_0010;
      22: return 32'h0011_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] bWm(int i, bit up);
    case (i)
      1: return 32'h0000_0547;  3: return 32'h0000_00ff;
      4: return up ? 32'hfffe_0000 : 32'h0;  5: return up ? 32'hffff_ffff : 32'h0;
      6: return 32'h00ff_ffff;  7: return 32'h0000_f0f0;
      8, 9: return 32'hfff0_fff0;  10, 11, 12: return 32'hffff_ffff;
      15: return 32'h005f_00ff; 20: return 32'h0000_00ef;
      22: return up ? 32'h0000_00c3 : 32'h0000_00f3;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] bW1c(int i);
    case (i)
      1: return 32'hc900_0000; 7: return 32'hc100_0000; 20: return 32'h000f_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagOf(int i);
    case (i)
      1: return "R4"; 0, 2, 3: return "R5"; 4, 5: return "R6"; 6: return "R7";
      7, 8, 9, 10, 11, 12: return "R8"; 13, 15, 16: return "R9";
      18, 20, 22: return "R10"; default: return "R3";
    endcase
  endfunction

  function automatic logic [2:0] expWin(int i, logic [3:0] be);
    if ((i == 7 && (be[0] || be[1])) || i == 12) return 3'b001;
    if (i == 8) return 3'b010;
    if (i >= 9 && i <= 11) return 3'b100;
    return 3'b000;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset(bit up);
    @(negedge clk);
    rstN = 1'b0; upstream = up;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 24; i++) model[i] = bRst(i, up);
    @(negedge clk);
    chk("R2 reset cplValid", {31'h0, cplValid}, 32'h0);
    chk("R11 reset fwdValid", {31'h0, fwdValid}, 32'h0);
    chk("R12 reset winUpdValid", {31'h0, winUpdValid}, 32'h0);
  endtask

  // Called at a negedge; returns at the following negedge after checking.
  task automatic acc(bit t1, bit wr, logic [15:0] byteAddr, logic [3:0] be, logic [31:0] d);
    int i;
    bit ur, ca;
    logic [31:0] expRd, lm;
    logic [2:0] expSt, win;
    i = int'(byteAddr[15:2]);
    ur = byteAddr >= 16'h1000;
    ca = (be == 4'h0);
    expSt = ur ? 3'b001 : (ca ? 3'b100 : 3'b000);
    expRd = (!t1 && !wr && !ur && !ca && i < 24) ? model[i] : 32'h0;
    win = (!t1 && wr && !ur && !ca) ? expWin(i, be) : 3'b000;
    reqValid = 1'b1; reqType1 = t1; reqWrite = wr; reqDwAddr = byteAddr[15:2];
    reqBe = be; reqWdata = d; priStatusSet = pendPri; secStatusSet = pendSec;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; priStatusSet = '0; secStatusSet = '0;
    if (t1) begin
      chk("R11 fwdValid", {31'h0, fwdValid}, 32'h1);
      chk("R11 no local cpl", {31'h0, cplValid}, 32'h0);
      chk("R11 fwd fields", {fwdWrite, fwdBe, fwdDwAddr}, {wr, be, byteAddr[15:2]});
      chk("R11 fwd data", fwdWdata, d);
    end else begin
      chk("R2 cplValid", {31'h0, cplValid}, 32'h1);
      chk(ur ? "R1 status" : "R2 status", {29'h0, cplStatus}, {29'h0, expSt});
      chk(ur ? "R1 rdata" : tagOf(i), cplRdata, expRd);
      chk("R12 window pulse", {28'h0, winUpdValid, winUpdSel}, {28'h0, |win, win});
    end
    if (!t1 && wr && !ur && !ca && i < 24) begin
      lm = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
      model[i] = (model[i] & ~(bWm(i, upstream) & lm)) | (d & bWm(i, upstream) & lm);
      model[i] = model[i] & ~(d & bW1c(i) & lm);
    end
    model[1] = model[1] | ({pendPri, 16'h0} & bW1c(1));
    model[7] = model[7] | ({pendSec, 16'h0} & bW1c(7));
    pendPri = '0; pendSec = '0;
  endtask

  task automatic rd(logic [15:0] a); acc(0, 0, a, 4'hf, 32'h0); endtask
  task automatic wrt(logic [15:0] a, logic [3:0] be, logic [31:0] d); acc(0, 1, a, be, d); endtask

  task automatic runMode(bit up);
    doReset(up);
    // Reset values of every dword, and a step past the implemented range (R3)
    for (int i = 0; i < 26; i++) rd(16'(i * 4));
    // Masks: write all ones everywhere and read back
    for (int i = 0; i < 24; i++) begin wrt(16'(i * 4), 4'hf, 32'hffff_ffff); rd(16'(i * 4)); end
    // R3 lane gating on bus number dword
    wrt(16'h0018, 4'b0010, 32'h1234_5678); rd(16'h0018);
    wrt(16'h0018, 4'b0101, 32'hAAAA_AAAA); rd(16'h0018);
    // R2 abort: zero byte enables must not write
    wrt(16'h0018, 4'h0, 32'h0); rd(16'h0018);
    // R1 out of space
    wrt(16'h1018, 4'hf, 32'h0); rd(16'h1000); rd(16'hfffc); rd(16'h0018);
    // R4 W1C with set: idle set then clear, then simultaneous set and clear
    pendPri = 16'hffff; rd(16'h0000); rd(16'h0004);
    wrt(16'h0004, 4'b1000, 32'h4000_0000); rd(16'h0004);
    pendPri = 16'h8000; wrt(16'h0004, 4'b1100, 32'hffff_0000); rd(16'h0004);
    // R8 secondary status set; lanes 2/3 only raise no window pulse (R12)
    pendSec = 16'hffff; wrt(16'h001C, 4'b1100, 32'h0100_0000); rd(16'h001C);
    wrt(16'h001C, 4'b0001, 32'h0000_0030); rd(16'h001C);
    // R11 Type 1 forwarding leaves local state alone
    acc(1, 1, 16'h0018, 4'hf, 32'hdead_beef); acc(1, 0, 16'h0104, 4'h3, 32'h0); rd(16'h0018);
    // Random mix
    for (int n = 0; n < 600; n++) begin
      int sel;
      logic [15:0] a;
      sel = int'($urandom_range(0, 99));
      a = (sel < 8) ? 16'(16'h1000 + ($urandom_range(0, 255) * 4)) : 16'($urandom_range(0, 27) * 4);
      if ($urandom_range(0, 9) == 0) pendPri = 16'($urandom);
      if ($urandom_range(0, 9) == 0) pendSec = 16'($urandom);
      acc(sel >= 92, 1'($urandom), a, 4'($urandom), $urandom);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    runMode(1'b1);
    runMode(1'b0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule